// File: doc/BRIEF.md
# Raster Timing Generator

This block is the raster timing generator for one video output. Software sets it up through a simple 32-bit write bus. The setup covers the horizontal and vertical timings, a kick position, an output mode for normal operation, a second mode for panic, and a constant green level.

From the running pixel and line counters the block produces the following outputs:
- active-high horizontal and vertical sync;
- a data-enable strobe;
- a one-cycle kick pulse;
- the pixel word for the current position.

A timestamp word can be read back at any time. It holds a frame count and the current line number.

The timing and kick words can be double-buffered. When buffering is on, writes land in shadow copies. Those copies become live only when software requests a load, and only at the next entry into vertical blanking. A whole new video mode can therefore be staged without tearing the frame that is on screen.

Top module: `frame_timer`

## Requirements
- R1: After reset the pixel counter, line counter, hsync, vsync, de, kick, pix_out and the timestamp read all return zero.
- R2: Once running, the pixel counter counts 0 up to htotal−1 and wraps. The line counter advances at each pixel wrap and wraps after vtotal−1, and the frame index then increments. Reading byte address 0x2C returns the frame index in bits 31:14 and the line counter in bits 13:0. Any other read address returns zero.
- R3: de is high only while running with pixel < active width and line < active height. Active width is bits 13:0 of address 0x04; active height is bits 13:0 of address 0x0C.
- R4: Address 0x04 holds htotal−1 in bits 29:16. Address 0x08 holds sync width−1 in bits 13:0, (htotal − sync start)−1 in bits 29:16, and a sync enable in bit 31. hsync is high for pixels from the sync start up to, but not including, sync start + width, only when enabled and running. Addresses 0x0C and 0x10 define vsync in the same way, counted in lines.
- R5: Address 0x14 holds the kick column in bits 13:0, the kick row in bits 29:16 and an enable in bit 31. kick is high for exactly the cycle in which the counters equal that column and row while running.
- R6: Bit 0 of address 0x00 turns shadowing on. While it is on, writes to 0x04–0x14 are held and have no effect until a 1 is written to bit 0 of address 0x28. The held values then take effect from the first cycle of line active-height, and the request clears. While shadowing is off, those writes take effect on the next cycle.
- R7: The mode field is bits 2:0 of address 0x18. Mode 1 outputs green = bits 19:10 of address 0x20, placed in pix_out[19:10] with the other bits zero. Mode 5 outputs sec_pix when sec_valid is high and pri_pix otherwise. Any other mode outputs zero. pix_out is zero whenever de is low.
- R8: While panic is high, the mode field is taken from bits 2:0 of address 0x1C instead of 0x18.
- R9: Bit 0 of address 0x24 starts the counters with 1 and stops them with 0. Stopping returns the pixel and line counters to zero and keeps the frame index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_waddr | input | 8 | Write byte address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 8 | Read byte address |
| bus_rdata | output | 32 | Read data (combinational) |
| panic | input | 1 | Selects the panic mode word |
| pri_pix | input | 30 | Primary layer pixel |
| sec_pix | input | 30 | Secondary layer pixel |
| sec_valid | input | 1 | Secondary pixel is opaque |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| kick | output | 1 | Kick pulse |
| pix_x | output | 14 | Pixel counter |
| line_y | output | 14 | Line counter |
| pix_out | output | 30 | Output pixel |

## Verification
The hardest situation to reach from the ports is a shadow load that is pending for a long time. The staged line length must stay hidden while the old frame keeps running. It must then switch over on exactly the first blanking line.

To reach it, the stimulus enables shadowing mid-frame and writes a longer horizontal total. It then runs for more than a full frame without a load request. Only after that does it raise the request, still mid-frame. A behavioural model is compared against every output on every cycle, so the exact cycle of the switch is checked. Directed checks on the longest observed pixel count confirm the line length both before and after the switch.

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int CH_W = 10,
  parameter int AW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_waddr,
  input  logic [31:0]         bus_wdata,
  input  logic [AW-1:0]       bus_raddr,
  output logic [31:0]         bus_rdata,
  input  logic                panic,
  input  logic [3*CH_W-1:0]   pri_pix,
  input  logic [3*CH_W-1:0]   sec_pix,
  input  logic                sec_valid,
  output logic                hsync,
  output logic                vsync,
  output logic                de,
  output logic                kick,
  output logic [13:0]         pix_x,
  output logic [13:0]         line_y,
  output logic [3*CH_W-1:0]   pix_out
);
  localparam int PW    = 3 * CH_W;
  localparam int FRM_W = 18;
  localparam int NCFG  = 5;
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h00);
  localparam logic [AW-1:0] A_CFG0  = AW'(8'h04);
  localparam logic [AW-1:0] A_CFGN  = AW'(8'h14);
  localparam logic [AW-1:0] A_MODE  = AW'(8'h18);
  localparam logic [AW-1:0] A_PMODE = AW'(8'h1C);
  localparam logic [AW-1:0] A_COLR  = AW'(8'h20);
  localparam logic [AW-1:0] A_RUN   = AW'(8'h24);
  localparam logic [AW-1:0] A_LOAD  = AW'(8'h28);
  localparam logic [AW-1:0] A_STAMP = AW'(8'h2C);
  localparam logic [2:0] M_CONST = 3'd1;
  localparam logic [2:0] M_LAYER = 3'd5;

  logic [31:0]      shd [NCFG];
  logic [31:0]      act [NCFG];
  logic             shen, token, run;
  logic [2:0]       mode, pmode, msel;
  logic [CH_W-1:0]  green;
  logic [13:0]      hcnt, vcnt;
  logic [FRM_W-1:0] frame;

  wire [AW-1:0] woff   = bus_waddr - A_CFG0;
  wire [2:0]    widx   = woff[4:2];
  wire          cfg_wr = bus_we && bus_waddr >= A_CFG0 && bus_waddr <= A_CFGN && bus_waddr[1:0] == 2'b00;
  wire          ld_wr  = bus_we && bus_waddr == A_LOAD && bus_wdata[0];

  wire [13:0] hact    = act[0][13:0];
  wire [13:0] htot_m1 = act[0][29:16];
  wire [13:0] hs_m1   = act[1][13:0];
  wire [13:0] hsbp_m1 = act[1][29:16];
  wire        hs_en   = act[1][31];
  wire [13:0] vact    = act[2][13:0];
  wire [13:0] vtot_m1 = act[2][29:16];
  wire [13:0] vs_m1   = act[3][13:0];
  wire [13:0] vsbp_m1 = act[3][29:16];
  wire        vs_en   = act[3][31];
  wire [13:0] kcol    = act[4][13:0];
  wire [13:0] krow    = act[4][29:16];
  wire        k_en    = act[4][31];

  wire h_end = hcnt >= htot_m1;
  wire v_end = vcnt >= vtot_m1;
  wire xfer  = token && run && h_end && vcnt == vact - 14'd1;

  wire [14:0] hstart = {1'b0, htot_m1 - hsbp_m1};
  wire [14:0] hstop  = hstart + {1'b0, hs_m1} + 15'd1;
  wire [14:0] vstart = {1'b0, vtot_m1 - vsbp_m1};
  wire [14:0] vstop  = vstart + {1'b0, vs_m1} + 15'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) begin
        shd[i] <= '0;
        act[i] <= '0;
      end
      shen  <= 1'b0;
      token <= 1'b0;
      run   <= 1'b0;
      mode  <= '0;
      pmode <= '0;
      green <= '0;
    end else begin
      if (xfer) begin
        for (int i = 0; i < NCFG; i++) act[i] <= shd[i];
        token <= 1'b0;
      end
      if (cfg_wr) begin
        shd[widx] <= bus_wdata;
        if (!shen) act[widx] <= bus_wdata;
      end
      if (ld_wr) token <= 1'b1;
      if (bus_we) begin
        case (bus_waddr)
          A_CTRL:  shen  <= bus_wdata[0];
          A_MODE:  mode  <= bus_wdata[2:0];
          A_PMODE: pmode <= bus_wdata[2:0];
          A_COLR:  green <= bus_wdata[10+CH_W-1:10];
          A_RUN:   run   <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      vcnt  <= '0;
      frame <= '0;
    end else if (!run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_end) begin
      hcnt <= '0;
      if (v_end) begin
        vcnt  <= '0;
        frame <= frame + 1'b1;
      end else begin
        vcnt <= vcnt + 14'd1;
      end
    end else begin
      hcnt <= hcnt + 14'd1;
    end
  end

  assign pix_x  = hcnt;
  assign line_y = vcnt;
  assign de     = run && hcnt < hact && vcnt < vact;
  assign hsync  = run && hs_en && {1'b0, hcnt} >= hstart && {1'b0, hcnt} < hstop;
  assign vsync  = run && vs_en && {1'b0, vcnt} >= vstart && {1'b0, vcnt} < vstop;
  assign kick   = run && k_en && hcnt == kcol && vcnt == krow;
  assign msel   = panic ? pmode : mode;

  always_comb begin
    pix_out = '0;
    if (de) begin
      case (msel)
        M_CONST: pix_out[10+CH_W-1:10] = green;
        M_LAYER: pix_out = sec_valid ? sec_pix : pri_pix;
        default: pix_out = '0;
      endcase
    end
  end

  assign bus_rdata = (bus_raddr == A_STAMP) ? {frame, vcnt} : 32'd0;

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == 14'd0 && vcnt == 14'd0));
  p_pixel_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !h_end) |=> hcnt == $past(hcnt) + 14'd1);
  p_frame_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_end && v_end) |=> frame == $past(frame) + 1'b1);
  p_token_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ld_wr) |=> !token);
  p_active_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !(cfg_wr && !shen)) |=> (act[0] == $past(act[0]) && act[4] == $past(act[4])));
  p_kick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && hcnt != htot_m1) |=> !kick);
endmodule

// File: tb/sim_frame_timer.sv
`timescale 1ns/1ps
module sim_frame_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0] bus_raddr = 8'h2C;
  logic [31:0] bus_rdata;
  logic panic = 1'b0;
  logic [29:0] pri_pix = '0, sec_pix = '0, pix_out;
  logic sec_valid = 1'b0;
  logic hsync, vsync, de, kick;
  logic [13:0] pix_x, line_y;

  int checks = 0, failures = 0;
  bit model_on = 1'b0;
  int seed = 1;

  always #2 clk = ~clk;

  frame_timer u0 (.clk, .rst_n, .bus_we, .bus_waddr, .bus_wdata, .bus_raddr, .bus_rdata,
    .panic, .pri_pix, .sec_pix, .sec_valid, .hsync, .vsync, .de, .kick, .pix_x, .line_y, .pix_out);

  // behavioural reference
  int m_shd[5], m_act[5];
  int m_h = 0, m_v = 0, m_frame = 0, m_run = 0, m_shen = 0, m_tok = 0;
  int m_mode = 0, m_pmode = 0, m_green = 0;

  function automatic int fld(int w, int lo);
    return (w >> lo) & 'h3FFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin m_shd[i] = 0; m_act[i] = 0; end
      m_h = 0; m_v = 0; m_frame = 0; m_run = 0; m_shen = 0; m_tok = 0;
      m_mode = 0; m_pmode = 0; m_green = 0;
    end else begin
      int nh, nv, nf;
      bit hend, vend;
      hend = m_h >= fld(m_act[0], 16);
      vend = m_v >= fld(m_act[2], 16);
      nh = m_h; nv = m_v; nf = m_frame;
      if (!m_run) begin nh = 0; nv = 0; end
      else if (hend) begin
        nh = 0;
        if (vend) begin nv = 0; nf = (m_frame + 1) % (1 << 18); end
        else nv = m_v + 1;
      end else nh = m_h + 1;
      if (m_tok && m_run && hend && m_v == fld(m_act[2], 0) - 1) begin
        for (int i = 0; i < 5; i++) m_act[i] = m_shd[i];
        m_tok = 0;
      end
      if (bus_we) begin
        if (bus_waddr >= 8'h04 && bus_waddr <= 8'h14 && bus_waddr[1:0] == 0) begin
          m_shd[(bus_waddr - 4) / 4] = int'(bus_wdata);
          if (!m_shen) m_act[(bus_waddr - 4) / 4] = int'(bus_wdata);
        end
        case (bus_waddr)
          8'h00: m_shen = int'(bus_wdata[0]);
          8'h18: m_mode = int'(bus_wdata[2:0]);
          8'h1C: m_pmode = int'(bus_wdata[2:0]);
          8'h20: m_green = int'(bus_wdata[19:10]);
          8'h24: m_run = int'(bus_wdata[0]);
          8'h28: if (bus_wdata[0]) m_tok = 1;
          default: ;
        endcase
      end
      m_h = nh; m_v = nv; m_frame = nf;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      int e_de, e_hs, e_vs, e_k, e_pix, sel, hst, vst;
      e_de = (m_run && m_h < fld(m_act[0], 0) && m_v < fld(m_act[2], 0)) ? 1 : 0;
      hst = fld(m_act[0], 16) - fld(m_act[1], 16);
      vst = fld(m_act[2], 16) - fld(m_act[3], 16);
      e_hs = (m_run && m_act[1][31] && m_h >= hst && m_h < hst + fld(m_act[1], 0) + 1) ? 1 : 0;
      e_vs = (m_run && m_act[3][31] && m_v >= vst && m_v < vst + fld(m_act[3], 0) + 1) ? 1 : 0;
      e_k = (m_run && m_act[4][31] && m_h == fld(m_act[4], 0) && m_v == fld(m_act[4], 16)) ? 1 : 0;
      sel = panic ? m_pmode : m_mode;
      e_pix = 0;
      if (e_de != 0) begin
        if (sel == 1) e_pix = m_green << 10;
        else if (sel == 5) e_pix = sec_valid ? int'(sec_pix) : int'(pri_pix);
      end
      chk(pix_x == 14'(m_h) && line_y == 14'(m_v), "R2 counters", {pix_x, line_y}, {14'(m_h), 14'(m_v)});
      chk(bus_rdata == {18'(m_frame), 14'(m_v)}, "R2 timestamp", bus_rdata, {18'(m_frame), 14'(m_v)});
      chk(de == e_de[0], "R3 de", de, e_de);
      chk(hsync == e_hs[0] && vsync == e_vs[0], "R4 sync", {hsync, vsync}, {e_hs[0], e_vs[0]});
      chk(kick == e_k[0], "R5 kick", kick, e_k);
      chk(pix_out == 30'(e_pix), panic ? "R8 panic pixel" : "R7 pixel", pix_out, e_pix);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      seed = seed * 1103515245 + 12345;
      pri_pix = 30'(seed);
      sec_pix = 30'(seed >> 3) ^ 30'h155;
      sec_valid = seed[9];
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic max_x(input int n, output int mx);
    mx = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (int'(pix_x) > mx) mx = int'(pix_x);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mx;
    logic [17:0] fr;
    step(3);
    chk({hsync, vsync, de, kick} == 4'b0 && pix_x == 0 && line_y == 0 && pix_out == 0 && bus_rdata == 0,
        "R1 reset state", {hsync, vsync, de, kick, pix_x, line_y}, 0);
    rst_n = 1'b1;
    step(2);
    chk(pix_x == 0 && bus_rdata == 0, "R1 held after reset", {pix_x, bus_rdata}, 0);
    model_on = 1'b1;
    wr(8'h04, (11 << 16) | 6);
    wr(8'h08, 32'h8000_0000 | (3 << 16) | 1);
    wr(8'h0C, (7 << 16) | 4);
    wr(8'h10, 32'h8000_0000 | (2 << 16) | 0);
    wr(8'h14, 32'h8000_0000 | (4 << 16) | 7);
    wr(8'h18, 5);
    wr(8'h1C, 1);
    wr(8'h20, 32'h2AB << 10);
    wr(8'h24, 1);
    step(200);
    wr(8'h18, 1);
    step(100);
    wr(8'h18, 7);
    step(50);
    wr(8'h18, 5);
    step(30);
    panic = 1'b1;
    do step(1); while (!de);
    chk(pix_out == 30'(32'h2AB << 10), "R8 panic selects constant green", pix_out, 32'h2AB << 10);
    step(60);
    panic = 1'b0;
    step(20);
    // R6: staged line length stays hidden until the load request
    wr(8'h00, 1);
    wr(8'h04, (15 << 16) | 6);
    max_x(150, mx);
    chk(mx == 11, "R6 shadow write held", mx, 11);
    wr(8'h28, 1);
    do step(1); while (!(line_y == 4 && pix_x == 0));
    max_x(40, mx);
    chk(mx == 15, "R6 shadow applied at blanking", mx, 15);
    step(200);
    fr = bus_rdata[31:14];
    chk(fr != 0, "R2 frame index advanced", fr, 1);
    wr(8'h24, 0);
    step(2);
    chk(pix_x == 0 && line_y == 0 && bus_rdata[31:14] == fr && !de && !hsync,
        "R9 stop zeroes counters keeps frame", {bus_rdata, pix_x}, {fr, 14'd0, 14'd0});
    wr(8'h24, 1);
    step(50);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule